// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream into parallel samples: a bit clock, a frame clock that tells the left slot from the right slot, and one data line. All three wires are oversampled in the system clock domain. Each bit is taken on a rising edge of the bit clock. When the right channel of a frame closes, the block presents both 24-bit words together with a single-cycle strobe.

A 3-bit format code selects one of six layouts:

- right-justified at 16, 20 or 24 bits;
- left-justified at 24 bits;
- the common inter-IC sound format at 16 or 24 bits.

A polarity input swaps the frame-clock levels for every format except the inter-IC one. A two-bit selector taps one bit of each word at the 16th, 20th or 24th position from the MSB, for a downstream decoder that reads a code hidden in the low bits.

The block also counts where each frame starts, measured in bit clocks against a free-running frame counter. If a frame start drifts by more than a set number of bit clocks, the block raises a resync flag, drops that frame and forces both words to zero. It releases them when the next correctly spaced frame arrives.

Top module: `pcm_serial_rx`

## Requirements
- R1: `fmt_i` = {width1, width0, i2s} decodes as follows: 000 is 16-bit right-justified, 010 is 20-bit right-justified, 100 is 24-bit right-justified, 110 is 24-bit left-justified, 001 is 16-bit inter-IC and 011 is 24-bit inter-IC.
- R2: Data is MSB-first two's complement, sampled on bit-clock rising edges. Each N-bit sample is output MSB-aligned in 24 bits, so sample bit N-1 lands on output bit 23 and the low 24-N bits are zero.
- R3: In the right-justified formats the word is the last N bits before the frame-clock change. Any number of padding bits ahead of it, of any value, has no effect.
- R4: In the inter-IC formats the MSB is the second bit after the frame-clock change, and a low frame clock marks the left channel whatever `lr_swap_i` is.
- R5: In the right- and left-justified formats, a high frame clock marks the left channel when `lr_swap_i` = 0 and a low frame clock marks it when `lr_swap_i` = 1.
- R6: `valid_o` is a one-cycle pulse issued when a left-channel slot starts. With it, `left_o`/`right_o` carry the two words of the frame that just ended, and every accepted frame produces exactly one pulse.
- R7: The start of each frame is compared against a bit-clock counter that wraps every FRAME_BITS (64) bits.
  - An offset of up to SLIP_MAX (6) bits either way is accepted.
  - A larger offset raises `resync_o`, drops the frame and realigns the counter.
  - While `resync_o` is high, both words read zero.
  - `resync_o` falls when the next frame of correct length is accepted.
- R8: After reset `valid_o` = 0, `resync_o` = 1 and both words are 0. The first frame start only sets the alignment, so the first frame is not emitted.
- R9: The reserved format codes 101 and 111 never produce `valid_o`.
- R10: `hid_sel_i` selects the tapped bit of each output word: 00 taps the 16th bit from the MSB (word bit 8), 01 the 20th (bit 4), 11 the 24th (bit 0). The reserved value 10 drives `hid_l_o`/`hid_r_o` to 0.
- R11: In the 24-bit left-justified format the MSB is the first bit after the frame-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous, oversampled) |
| lrclk_i | input | 1 | Frame clock marking left/right slots |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Format code {width1, width0, i2s} |
| lr_swap_i | input | 1 | Frame-clock polarity swap (non inter-IC formats) |
| hid_sel_i | input | 2 | Hidden-code tap position select |
| left_o | output | 24 | Left word, MSB-aligned |
| right_o | output | 24 | Right word, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe for a completed frame |
| resync_o | output | 1 | Frame alignment being re-established |
| hid_l_o | output | 1 | Tapped bit of the left word |
| hid_r_o | output | 1 | Tapped bit of the right word |

## Verification
Timing of the results:
- Every result follows a bit-clock rising edge through two synchronizer stages and one state register. `valid_o`, the new words and the `resync_o` update are therefore due three system clocks after that edge.
- The edge in question samples the first bit of a left slot.

How the bench keeps to it:
- The driver pushes each frame's expected pair into a queue.
- A monitor samples on falling clock edges and pops from the queue only when `valid_o` is seen. It does not wait a fixed count.
- The `resync_o` level and the forced zero words are checked at the end of a frame. That point is at least 32 system clocks after any register could change and before the next frame start reaches the outputs.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int WORD_W = 24;

  typedef enum logic [1:0] {
    JUST_RIGHT = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_IIS   = 2'd2,
    JUST_NONE  = 2'd3
  } just_e;

  // Justification implied by the format code {width1, width0, i2s}.
  function automatic just_e fmt_just(input logic [2:0] code);
    case (code)
      3'b000, 3'b010, 3'b100: fmt_just = JUST_RIGHT;
      3'b110:                 fmt_just = JUST_LEFT;
      3'b001, 3'b011:         fmt_just = JUST_IIS;
      default:                fmt_just = JUST_NONE;
    endcase
  endfunction

  // Sample length in bits implied by the format code.
  function automatic logic [4:0] fmt_len(input logic [2:0] code);
    case (code)
      3'b000, 3'b001: fmt_len = 5'd16;
      3'b010:         fmt_len = 5'd20;
      default:        fmt_len = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_edge.sv
// Brings bit clock, frame clock and data into the system clock domain and
// flags each bit-clock rising edge; all three wires see equal delay.
module pcm_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic tick_o,
  output logic lr_o,
  output logic sd_o
);
  logic [STAGES:0]   b_q;
  logic [STAGES-1:0] l_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      l_q <= '0;
      d_q <= '0;
    end else begin
      b_q <= {b_q[STAGES-1:0], bclk_i};
      l_q <= {l_q[STAGES-2:0], lrclk_i};
      d_q <= {d_q[STAGES-2:0], sdata_i};
    end
  end

  assign tick_o = b_q[STAGES-1] & ~b_q[STAGES];
  assign lr_o   = l_q[STAGES-1];
  assign sd_o   = d_q[STAGES-1];
endmodule

// File: rtl/pcm_rx_capture.sv
// Slot tracking and word assembly for every justification.
module pcm_rx_capture
  import pcm_rx_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              lr_i,
  input  logic              sd_i,
  input  logic [2:0]        fmt_i,
  input  logic              lr_swap_i,
  output logic              edge_o,
  output logic              ended_left_o,
  output logic              started_left_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int WIN_W = IDX_W + 1;

  logic              lr_prev_q, lr_prev_n;
  logic [IDX_W-1:0]  idx_q, idx_n, idx_eff;
  logic [WORD_W-1:0] sh_q, sh_n, base;
  just_e             just;
  logic [4:0]        len;
  logic [4:0]        shamt;
  logic [WIN_W-1:0]  win_lo, win_hi;
  logic              in_win;

  function automatic logic is_left(input logic lvl, input just_e j, input logic swap);
    is_left = (j == JUST_IIS) ? ~lvl : (lvl ^ swap);
  endfunction

  always_comb begin
    just    = fmt_just(fmt_i);
    len     = fmt_len(fmt_i);
    shamt   = 5'(WORD_W) - len;
    edge_o  = tick_i && (lr_i != lr_prev_q);
    idx_eff = edge_o ? '0 : idx_q;
    win_lo  = (just == JUST_IIS) ? WIN_W'(1) : '0;
    win_hi  = win_lo + WIN_W'(len);
    in_win  = (just == JUST_RIGHT) ||
              ({1'b0, idx_eff} >= win_lo && {1'b0, idx_eff} < win_hi);
    base    = edge_o ? '0 : sh_q;

    lr_prev_n = lr_prev_q;
    idx_n     = idx_q;
    sh_n      = sh_q;
    if (tick_i) begin
      lr_prev_n = lr_i;
      if (edge_o)             idx_n = IDX_W'(1);
      else if (~&idx_q)       idx_n = idx_q + 1'b1;
      sh_n = in_win ? {base[WORD_W-2:0], sd_i} : base;
    end

    ended_left_o   = is_left(lr_prev_q, just, lr_swap_i);
    started_left_o = is_left(lr_i, just, lr_swap_i);
    word_o         = sh_q << shamt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
    end else begin
      lr_prev_q <= lr_prev_n;
      idx_q     <= idx_n;
      sh_q      <= sh_n;
    end
  end
endmodule

// File: rtl/pcm_rx_phase.sv
// Frame-start alignment against a free-running bit-clock counter.
module pcm_rx_phase #(
  parameter int FRAME_BITS = 64,
  parameter int SLIP_MAX   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic accept_o,
  output logic resync_o
);
  localparam int PW    = $clog2(FRAME_BITS);
  localparam int ERR_W = PW + 1;
  localparam int HALF  = FRAME_BITS / 2;

  logic [PW-1:0]    pos_q, pos_n;
  logic             acq_q, acq_n;
  logic             rs_q, rs_n;
  logic [ERR_W-1:0] err;
  logic             mis;

  always_comb begin
    err = ({1'b0, pos_q} <= ERR_W'(HALF)) ? {1'b0, pos_q}
                                          : ERR_W'(FRAME_BITS) - {1'b0, pos_q};
    mis      = !acq_q || (err > ERR_W'(SLIP_MAX));
    accept_o = start_i && !mis;

    pos_n = pos_q;
    acq_n = acq_q;
    rs_n  = rs_q;
    if (tick_i) begin
      if (start_i && mis)                   pos_n = PW'(1);
      else if (pos_q == PW'(FRAME_BITS - 1)) pos_n = '0;
      else                                   pos_n = pos_q + 1'b1;
    end
    if (start_i) begin
      acq_n = 1'b1;
      rs_n  = mis;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      acq_q <= 1'b0;
      rs_q  <= 1'b1;
    end else begin
      pos_q <= pos_n;
      acq_q <= acq_n;
      rs_q  <= rs_n;
    end
  end

  assign resync_o = rs_q;
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int FRAME_BITS  = 64,
  parameter int SLIP_MAX    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  input  logic [2:0]        fmt_i,
  input  logic              lr_swap_i,
  input  logic [1:0]        hid_sel_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o,
  output logic              resync_o,
  output logic              hid_l_o,
  output logic              hid_r_o
);
  logic              tick, lr_s, sd_s;
  logic              ch_edge, ended_left, started_left, accept;
  logic [WORD_W-1:0] word;
  logic              fmt_ok;
  logic [WORD_W-1:0] left_q, left_n, right_q, right_n;
  logic              valid_q, valid_n;

  function automatic logic tap(input logic [WORD_W-1:0] w, input logic [1:0] sel);
    case (sel)
      2'b00:   tap = w[WORD_W-16];
      2'b01:   tap = w[WORD_W-20];
      2'b11:   tap = w[WORD_W-24];
      default: tap = 1'b0;
    endcase
  endfunction

  pcm_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .sdata_i(sdata_i), .tick_o(tick), .lr_o(lr_s), .sd_o(sd_s)
  );

  pcm_rx_capture u_cap (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .lr_i(lr_s), .sd_i(sd_s),
    .fmt_i(fmt_i), .lr_swap_i(lr_swap_i), .edge_o(ch_edge),
    .ended_left_o(ended_left), .started_left_o(started_left), .word_o(word)
  );

  pcm_rx_phase #(.FRAME_BITS(FRAME_BITS), .SLIP_MAX(SLIP_MAX)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .start_i(ch_edge && started_left), .accept_o(accept), .resync_o(resync_o)
  );

  always_comb begin
    fmt_ok  = (fmt_just(fmt_i) != JUST_NONE);
    valid_n = accept && fmt_ok;
    left_n  = (ch_edge && fmt_ok &&  ended_left) ? word : left_q;
    right_n = (ch_edge && fmt_ok && !ended_left) ? word : right_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      left_q  <= left_n;
      right_q <= right_n;
      valid_q <= valid_n;
    end
  end

  assign valid_o = valid_q;
  assign left_o  = resync_o ? '0 : left_q;
  assign right_o = resync_o ? '0 : right_q;
  assign hid_l_o = tap(left_o, hid_sel_i);
  assign hid_r_o = tap(right_o, hid_sel_i);
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  fmt_i,
  input logic [1:0]  hid_sel_i,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o,
  input logic        resync_o,
  input logic        hid_l_o,
  input logic        hid_r_o
);
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_no_valid_in_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !resync_o);

  assert_resync_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |-> (left_o == 24'd0 && right_o == 24'd0));

  assert_resync_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(resync_o) && !$past(fmt_i[2] & fmt_i[0])) |-> valid_o);

  assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fmt_i[2] & fmt_i[0]) |-> !valid_o);

  assert_hid_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hid_sel_i == 2'b10) |-> (!hid_l_o && !hid_r_o));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .hid_sel_i(hid_sel_i),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
  .resync_o(resync_o), .hid_l_o(hid_l_o), .hid_r_o(hid_r_o)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic        swap = 1'b0;
  logic [1:0]  hsel = 2'b00;
  logic [23:0] left_o, right_o;
  logic        valid_o, resync_o, hid_l_o, hid_r_o;

  int errors = 0;
  int checks = 0;
  int valids = 0;
  bit done = 0;
  logic [47:0] expq[$];

  always #2.5 clk = ~clk;

  pcm_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
    .fmt_i(fmt), .lr_swap_i(swap), .hid_sel_i(hsel),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .resync_o(resync_o),
    .hid_l_o(hid_l_o), .hid_r_o(hid_r_o)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int flen();
    return (fmt[2:1] == 2'b00) ? 16 : (fmt == 3'b010) ? 20 : 24;
  endfunction
  function automatic bit is_iis();  return fmt[0]; endfunction
  function automatic bit left_lvl(); return is_iis() ? 1'b0 : !swap; endfunction

  function automatic logic [23:0] align(input logic [31:0] v);
    int n = flen();
    logic [31:0] m = (32'h1 << n) - 1;
    return 24'((v & m) << (24 - n));
  endfunction

  function automatic logic tapx(input logic [23:0] w);
    case (hsel)
      2'b00: return w[8];
      2'b01: return w[4];
      2'b11: return w[0];
      default: return 1'b0;
    endcase
  endfunction

  // Bit j of a channel slot holding N-bit value v; padding bits are 1.
  function automatic logic cbit(input logic [31:0] v, input int j, input int slots);
    int n = flen();
    if (fmt == 3'b110) return (j < n) ? v[n-1-j] : 1'b1;
    if (is_iis())      return (j >= 1 && j <= n) ? v[n-j] : 1'b1;
    return (j >= slots - n) ? v[n-1-(j-(slots-n))] : 1'b1;
  endfunction

  task automatic slot(input logic lvl, input logic d);
    @(negedge clk); bclk = 1'b0; lrclk = lvl; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_chan(input logic lvl, input logic [31:0] v, input int slots);
    for (int j = 0; j < slots; j++) slot(lvl, cbit(v, j, slots));
  endtask

  task automatic frame(input logic [31:0] l, input logic [31:0] r, input bit exp,
                       input int lslots = 32, input int rslots = 32);
    if (exp) expq.push_back({align(l), align(r)});
    send_chan(left_lvl(), l, lslots);
    send_chan(!left_lvl(), r, rslots);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {47'd0, valid_o}, 48'd0);
    chk("R8 reset resync", {47'd0, resync_o}, 48'd1);
    chk("R8 reset words", {left_o, right_o}, 48'd0);
    rst_n = 1'b1;
  endtask

  task automatic lead_in();
    for (int j = 0; j < 32; j++) slot(!left_lvl(), 1'b0);
  endtask

  task automatic flush(input string tag);
    slot(left_lvl(), 1'b0);
    slot(left_lvl(), 1'b0);
    repeat (20) @(negedge clk);
    chk({tag, " all frames emitted R6"}, 48'(expq.size()), 48'd0);
    expq.delete();
  endtask

  task automatic group(input logic [2:0] f, input logic sw, input logic [1:0] hs,
                       input int nfr, input string tag);
    fmt = f; swap = sw; hsel = hs;
    do_reset();
    lead_in();
    frame(32'h0000_8001, 32'h00FF_FFFF, 1'b1);
    chk({tag, " first frame only acquires R8"}, {47'd0, resync_o}, 48'd1);
    for (int k = 0; k < nfr; k++) frame($urandom, $urandom, 1'b1);
    chk({tag, " resync clear after aligned frame R7"}, {47'd0, resync_o}, 48'd0);
    flush(tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      valids++;
      if (expq.size() == 0) begin
        chk("R6/R9 unexpected valid", 48'd1, 48'd0);
      end else begin
        logic [47:0] e;
        e = expq.pop_front();
        chk("R2 left word (R1 R3 R4 R5 R11)", {24'd0, left_o}, {24'd0, e[47:24]});
        chk("R2 right word (R1 R3 R4 R5 R11)", {24'd0, right_o}, {24'd0, e[23:0]});
        chk("R10 hidden taps", {46'd0, hid_l_o, hid_r_o},
            {46'd0, tapx(e[47:24]), tapx(e[23:0])});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v0;
    group(3'b000, 1'b0, 2'b00, 3, "RJ16");
    group(3'b010, 1'b0, 2'b01, 3, "RJ20");
    group(3'b100, 1'b1, 2'b11, 3, "RJ24 swapped R5");
    group(3'b110, 1'b0, 2'b01, 3, "LJ24 R11");
    group(3'b110, 1'b1, 2'b10, 2, "LJ24 swapped R5");
    group(3'b001, 1'b1, 2'b00, 3, "IIS16 swap ignored R4");
    group(3'b011, 1'b0, 2'b11, 3, "IIS24 R4");

    // Reserved format codes
    fmt = 3'b101; swap = 1'b0; hsel = 2'b00;
    do_reset();
    v0 = valids;
    lead_in();
    for (int k = 0; k < 3; k++) frame($urandom, $urandom, 1'b0);
    fmt = 3'b111;
    for (int k = 0; k < 2; k++) frame($urandom, $urandom, 1'b0);
    slot(left_lvl(), 1'b0);
    repeat (20) @(negedge clk);
    chk("R9 reserved codes give no valid", 48'(valids - v0), 48'd0);

    // Phase slip: +6 accepted, further +1 forces resync
    fmt = 3'b100; swap = 1'b0; hsel = 2'b11;
    do_reset();
    lead_in();
    frame(32'h00_7FFFFF, 32'h00_800000, 1'b1);
    frame($urandom, $urandom, 1'b1, 32, 38);
    frame($urandom, $urandom, 1'b1);
    chk("R7 slip of 6 tolerated", {47'd0, resync_o}, 48'd0);
    frame($urandom, $urandom, 1'b0, 32, 33);
    frame(32'h00_123456, 32'h00_FEDCBA, 1'b1);
    chk("R7 slip of 7 raises resync", {47'd0, resync_o}, 48'd1);
    chk("R7 words zero during resync", {left_o, right_o}, 48'd0);
    frame($urandom, $urandom, 1'b1);
    chk("R7 resync released", {47'd0, resync_o}, 48'd0);
    flush("slip");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule